// File: doc/BRIEF.md
# Bidirectional Latched Serial-to-Parallel Driver

This block turns a serial bit stream into a wide parallel word. A chain of `N` stages (64 by default) takes one bit per rising edge of the shift clock. A direction input picks which end of the chain the data enters from. A bank of level-transparent latches sits behind the chain: it passes the chain contents through while the latch enable is high and holds the last value while it is low. Each parallel output then goes through blanking and polarity gating before it leaves the block.

A serial cascade output shows the stage at the far end of the chain for the current direction, so several instances can be chained into one long register. The chain shifts on every clock, whatever the latch, blank and polarity inputs are doing. The next frame can therefore be loaded while the current one is displayed.

Top module: `bidir_sipo_driver`

## Requirements
- R1: While `rst_ni` is low, all chain stages and all latches are zero. `ser_o` is 0, and with `blank_ni_i`=1 and `pol_i`=1 every `par_o` bit is 0.
- R2: With `dir_i`=0, each rising edge loads `ser_i` into stage 1 (`par_o[0]` side) and moves stage k to stage k+1.
- R3: With `dir_i`=1, each rising edge loads `ser_i` into stage N (`par_o[N-1]` side) and moves stage k to stage k-1.
- R4: `ser_o` equals stage N when `dir_i`=0 and stage 1 when `dir_i`=1, at all times.
- R5: While `le_i`=1, each latch follows its chain stage.
- R6: While `le_i`=0, the latches keep their values even though the chain keeps shifting.
- R7: With `blank_ni_i`=1, `par_o[k-1]` equals latch k when `pol_i`=1 and its inverse when `pol_i`=0.
- R8: With `blank_ni_i`=0, the latched value is replaced by 0 before the polarity stage. `par_o` is then all zeros when `pol_i`=1 and all ones when `pol_i`=0. The latch contents are left unchanged.
- R9: Shifting and `ser_o` do not depend on `le_i`, `blank_ni_i` or `pol_i`.
- R10: When `ser_o` of one instance drives `ser_i` of a second instance on the same clock, the two form a single chain of 2N stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shift clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ser_i | input | 1 | Serial data in |
| dir_i | input | 1 | 0: shift toward stage N, 1: shift toward stage 1 |
| le_i | input | 1 | Latch enable, transparent when high |
| blank_ni_i | input | 1 | Active-low blank |
| pol_i | input | 1 | 1: true outputs, 0: inverted outputs |
| par_o | output | N | Gated parallel outputs, bit k-1 from stage k |
| ser_o | output | 1 | Cascade output from the far stage |

## Verification
On every clock, the assertions check the single-step shift in each direction, the latch following the chain or holding still, and the outputs against the chain under transparency and blanking. Only the bench's scenarios can show end-to-end effects over many cycles. These are a bit travelling the full length in each direction, a held frame surviving a long stream of fresh data, the cascade tap swapping ends when the direction flips, and a two-instance chain delivering bits 2N cycles deep. The bench compares both instances against a queue-based model after every input change and after every clock edge.

// File: rtl/sipo_pkg.sv
package sipo_pkg;
  typedef enum logic {
    SHIFT_UP   = 1'b0,  // enter at stage 1, move toward stage N
    SHIFT_DOWN = 1'b1   // enter at stage N, move toward stage 1
  } shift_dir_e;
endpackage

// File: rtl/sipo_shift_chain.sv
module sipo_shift_chain
  import sipo_pkg::*;
#(
  parameter int unsigned N = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ser_i,
  input  shift_dir_e   dir_i,
  output logic [N-1:0] stage_o,
  output logic         tap_o
);
  logic [N-1:0] sr_q, sr_d;

  for (genvar k = 0; k < N; k++) begin : g_stage
    logic from_lo, from_hi;
    if (k == 0) begin : g_first
      assign from_lo = ser_i;
    end else begin : g_mid_lo
      assign from_lo = sr_q[k-1];
    end
    if (k == N-1) begin : g_last
      assign from_hi = ser_i;
    end else begin : g_mid_hi
      assign from_hi = sr_q[k+1];
    end
    assign sr_d[k] = (dir_i == SHIFT_DOWN) ? from_hi : from_lo;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= sr_d;
  end

  assign stage_o = sr_q;
  assign tap_o   = (dir_i == SHIFT_DOWN) ? sr_q[0] : sr_q[N-1];

  assert_fwd_shift_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_i == SHIFT_UP) |=> (sr_q[0] == $past(ser_i)) && (sr_q[N-1:1] == $past(sr_q[N-2:0])));

  assert_rev_shift_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_i == SHIFT_DOWN) |=> (sr_q[N-1] == $past(ser_i)) && (sr_q[N-2:0] == $past(sr_q[N-1:1])));
endmodule

// File: rtl/sipo_latch_bank.sv
module sipo_latch_bank #(
  parameter int unsigned N = 64
) (
  input  logic         clk_i,   // observation only
  input  logic         rst_ni,
  input  logic         le_i,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] lat_q;

  always_latch begin
    if (!rst_ni)   lat_q <= '0;
    else if (le_i) lat_q <= d_i;
  end

  assign q_o = lat_q;

  assert_transparent_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    le_i |-> (q_o == d_i));

  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!le_i && $past(!le_i)) |-> $stable(q_o));
endmodule

// File: rtl/sipo_out_gate.sv
module sipo_out_gate #(
  parameter int unsigned N = 64
) (
  input  logic         clk_i,   // observation only
  input  logic         rst_ni,
  input  logic [N-1:0] lat_i,
  input  logic         blank_ni,
  input  logic         pol_i,
  output logic [N-1:0] par_o
);
  for (genvar k = 0; k < N; k++) begin : g_out
    logic vis;
    assign vis      = lat_i[k] & blank_ni;  // blank before polarity
    assign par_o[k] = pol_i ? vis : ~vis;
  end

  assert_blank_level_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !blank_ni |-> (pol_i ? (par_o == '0) : (par_o == '1)));
endmodule

// File: rtl/bidir_sipo_driver.sv
module bidir_sipo_driver
  import sipo_pkg::*;
#(
  parameter int unsigned N = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ser_i,
  input  logic         dir_i,
  input  logic         le_i,
  input  logic         blank_ni_i,
  input  logic         pol_i,
  output logic [N-1:0] par_o,
  output logic         ser_o
);
  logic [N-1:0] stage, latched;

  sipo_shift_chain #(.N(N)) u_chain (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ser_i  (ser_i),
    .dir_i  (shift_dir_e'(dir_i)),
    .stage_o(stage),
    .tap_o  (ser_o)
  );

  sipo_latch_bank #(.N(N)) u_latch (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .le_i  (le_i),
    .d_i   (stage),
    .q_o   (latched)
  );

  sipo_out_gate #(.N(N)) u_gate (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lat_i   (latched),
    .blank_ni(blank_ni_i),
    .pol_i   (pol_i),
    .par_o   (par_o)
  );

  assert_true_pass_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (le_i && blank_ni_i && pol_i) |-> (par_o == stage));

  assert_inv_pass_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (le_i && blank_ni_i && !pol_i) |-> (par_o == ~stage));

  assert_reset_clear_R1: assert property (@(posedge clk_i)
    (!rst_ni && blank_ni_i && pol_i) |-> (par_o == '0) && !ser_o);
endmodule

// File: tb/bidir_sipo_driver_tb_top.sv
module bidir_sipo_driver_tb_top;
  localparam int N = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser = 1'b0, dir = 1'b0, le = 1'b1, blank_n = 1'b1, pol = 1'b1;
  logic [N-1:0] par_a, par_b;
  logic ser_a, ser_b;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;

  bit qa[$];   // index 0 = stage 1
  bit qb[$];
  bit la[N];
  bit lb[N];

  always #5 clk = ~clk;

  bidir_sipo_driver #(.N(N)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ser_i(ser), .dir_i(dir), .le_i(le),
    .blank_ni_i(blank_n), .pol_i(pol), .par_o(par_a), .ser_o(ser_a)
  );

  bidir_sipo_driver #(.N(N)) dut_b_i (
    .clk_i(clk), .rst_ni(rst_n), .ser_i(ser_a), .dir_i(dir), .le_i(le),
    .blank_ni_i(blank_n), .pol_i(pol), .par_o(par_b), .ser_o(ser_b)
  );

  function automatic bit tap(ref bit q[$]);
    return dir ? q[0] : q[N-1];
  endfunction

  function automatic logic [N-1:0] expect_par(ref bit l[N]);
    logic [N-1:0] v;
    for (int k = 0; k < N; k++) begin
      bit s = l[k] & blank_n;
      v[k] = pol ? s : ~s;
    end
    return v;
  endfunction

  task automatic model_reset();
    qa.delete(); qb.delete();
    for (int k = 0; k < N; k++) begin
      qa.push_back(1'b0); qb.push_back(1'b0); la[k] = 1'b0; lb[k] = 1'b0;
    end
  endtask

  task automatic model_latch();
    if (le) for (int k = 0; k < N; k++) begin la[k] = qa[k]; lb[k] = qb[k]; end
  endtask

  task automatic push(ref bit q[$], input bit b);
    if (dir) begin void'(q.pop_front()); q.push_back(b); end
    else     begin void'(q.pop_back());  q.push_front(b); end
  endtask

  task automatic model_shift();
    bit a_out = tap(qa);
    push(qa, ser);
    push(qb, a_out);
  endtask

  task automatic compare(input string tag);
    logic [N-1:0] ea = expect_par(la);
    logic [N-1:0] eb = expect_par(lb);
    vectors += 3;
    if (par_a !== ea) begin
      errors++; $display("FAIL %s par_o a: got %h exp %h", tag, par_a, ea);
    end
    if (ser_a !== tap(qa)) begin
      errors++; $display("FAIL %s ser_o a: got %b exp %b", tag, ser_a, tap(qa));
    end
    if (par_b !== eb) begin
      errors++; $display("FAIL %s par_o b: got %h exp %h", tag, par_b, eb);
    end
  endtask

  // one cycle: drive at negedge, check, clock, check
  task automatic step(input string tag, input bit s, input bit d, input bit l,
                      input bit b, input bit p);
    ser = s; dir = d; le = l; blank_n = b; pol = p;
    #1; model_latch(); compare(tag);
    @(posedge clk); model_shift();
    #1; model_latch(); compare(tag);
    @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
      end
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    #1; compare("R1");
    rst_n = 1'b1;
    @(negedge clk);

    // R2 / R5: forward shift, transparent latch, full length
    step("R2", 1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
    for (int i = 0; i < N + 6; i++) step("R2", 1'($urandom), 1'b0, 1'b1, 1'b1, 1'b1);
    for (int i = 0; i < 8; i++) step("R5", 1'($urandom), 1'b0, 1'b1, 1'b1, 1'b1);

    // R6: hold while the chain keeps moving
    for (int i = 0; i < 40; i++) step("R6", 1'($urandom), 1'b0, 1'b0, 1'b1, 1'b1);
    step("R5", 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);

    // R3 / R4: reverse shift, tap moves to stage 1
    step("R4", 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    for (int i = 0; i < N + 6; i++) step("R3", 1'($urandom), 1'b1, 1'b1, 1'b1, 1'b1);
    for (int i = 0; i < 10; i++) step("R4", 1'($urandom), 1'($urandom), 1'b1, 1'b1, 1'b1);

    // R7: inverted polarity, latched and transparent
    for (int i = 0; i < 12; i++) step("R7", 1'($urandom), 1'b0, 1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 6; i++) step("R7", 1'($urandom), 1'b0, 1'b0, 1'b1, 1'b0);

    // R8: blanking under both polarities, contents kept
    for (int i = 0; i < 6; i++) step("R8", 1'($urandom), 1'b0, 1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 6; i++) step("R8", 1'($urandom), 1'b0, 1'b0, 1'b0, 1'b0);
    step("R8", 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);

    // R9: control inputs toggling while shifting
    for (int i = 0; i < 60; i++)
      step("R9", 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));

    // R10: two-instance chain, forward, full 2N depth
    for (int i = 0; i < 2*N + 10; i++) step("R10", 1'($urandom), 1'b0, 1'b1, 1'b1, 1'b1);
    for (int i = 0; i < 2*N + 10; i++) step("R10", 1'($urandom), 1'b1, 1'b1, 1'b1, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule